// File: doc/BRIEF.md
# Prescaled Sampling Digital Input Filter

This block conditions one asynchronous input before it reaches edge-detection logic. The raw signal first passes through a two-flop synchronizer. A free-running prescaler then produces a one-cycle sample tick at a power-of-two fraction of the system clock. A run-length filter updates its output level only when the synchronized signal has shown the same new level on a required number of back-to-back sample ticks. Noise pulses shorter than the sampling window never appear at the output.

The sample period is set by a 3-bit divider code and by a base-select bit that picks either the undivided system clock or the system clock divided by two as the base. A mode bit selects whether two or three consecutive agreeing samples are needed. Downstream logic gets the clean level together with single-cycle rise and fall strobes.

Top module: `prescaled_input_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lvl_out`, `rise_pulse` and `fall_pulse` are all 0.
- R2: The raw input passes through exactly two synchronizer registers. With a sample period of 1 and two-sample mode, a step on `raw_in` that is applied before clock edge e0 is visible on `lvl_out` after edge e3 and not after edge e2.
- R3: The sample period in system clocks is (base_full ? 1 : 2) times 2 to the power `psc_code`. This gives 2..256 when `base_full`=0 and 1..128 when `base_full`=1.
- R4: The prescaler counter runs freely from reset with a period of 2. A new `psc_code` or `base_full` value is taken only at the end of the period in progress, so no period is truncated.
- R5: In two-sample mode (`three_smp`=0), `lvl_out` takes a new level on the second consecutive sample tick that shows that level.
- R6: In three-sample mode (`three_smp`=1), `lvl_out` takes a new level on the third consecutive sample tick that shows that level.
- R7: A sample equal to the current output level clears the run count. An input that toggles faster than the required run never changes `lvl_out`.
- R8: With a sample period of 2, a 4-clock pulse is always passed and a 2-clock pulse is always rejected in two-sample mode. In three-sample mode the figures are 6 and 4.
- R9: With a sample period of 256 in two-sample mode, a 512-clock pulse is always passed and a 256-clock pulse is always rejected.
- R10: `rise_pulse` (`fall_pulse`) is high for exactly one cycle, in the cycle in which `lvl_out` has just become 1 (0). One passed pulse yields one rise strobe and one fall strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Unsynchronized input signal |
| psc_code | input | 3 | Power-of-two sample divider code |
| base_full | input | 1 | 1: base is the system clock; 0: base is the system clock / 2 |
| three_smp | input | 1 | 1: three agreeing samples needed; 0: two |
| lvl_out | output | 1 | Filtered level |
| rise_pulse | output | 1 | One-cycle strobe on a filtered 0-to-1 change |
| fall_pulse | output | 1 | One-cycle strobe on a filtered 1-to-0 change |

## Verification
A prescaler that holds a wrong count or a wrong latched divider shifts every later sample tick. This appears at the ports as a level change one or more cycles too early or too late, and it shows at the first input edge after the fault, within one sample period. A corrupted run counter shows as a premature or missing level change on the next candidate run, so a cycle-accurate model compared on every clock exposes it within at most three sample periods. A stuck strobe register shows as a strobe whose level does not match the change of `lvl_out` in the same cycle.

// File: rtl/pif_pkg.sv
package pif_pkg;

  // Number of system clocks between sample ticks.
  function automatic int unsigned period_of(input int unsigned code, input bit full_rate);
    int unsigned base;
    base = full_rate ? 32'd1 : 32'd2;
    return base << code;
  endfunction

  // Consecutive agreeing samples required, minus one.
  function automatic logic [1:0] run_limit(input logic three);
    return three ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/pif_sync.sv
module pif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q[1] == $past(chain_q[0]));
endmodule

// File: rtl/pif_prescaler.sv
module pif_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              full_in,
  output logic              tick
);
  import pif_pkg::*;

  localparam int PER_W = (1 << CODE_W) + 1;

  logic [CODE_W-1:0] code_q;
  logic              full_q;
  logic [PER_W-1:0]  cnt_q;
  logic [PER_W-1:0]  per_w;
  logic              wrap;

  assign per_w = PER_W'(period_of(32'(code_q), full_q));
  assign wrap  = (cnt_q == per_w - 1'b1);
  assign tick  = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
      full_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      code_q <= code_in;
      full_q <= full_in;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_w);
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(code_q) && $stable(full_q)));
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
endmodule

// File: rtl/pif_level_filter.sv
module pif_level_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic smp,
  input  logic three,
  output logic lvl,
  output logic rise,
  output logic fall
);
  import pif_pkg::*;

  logic       lvl_q, rise_q, fall_q;
  logic [1:0] run_q;
  logic [1:0] need_m1;
  logic       differ;
  logic       accept;

  assign need_m1 = run_limit(three);
  assign differ  = (smp != lvl_q);
  assign accept  = tick && differ && (run_q >= need_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      run_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= accept && smp;
      fall_q <= accept && !smp;
      if (tick) begin
        if (!differ) begin
          run_q <= '0;
        end else if (accept) begin
          lvl_q <= smp;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign lvl  = lvl_q;
  assign rise = rise_q;
  assign fall = fall_q;

  // R6
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 2'd2);
  // R7
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !differ) |=> run_q == '0);
  // R5
  accept_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> lvl_q != $past(lvl_q));
endmodule

// File: rtl/prescaled_input_filter.sv
module prescaled_input_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic [2:0] psc_code,
  input  logic       base_full,
  input  logic       three_smp,
  output logic       lvl_out,
  output logic       rise_pulse,
  output logic       fall_pulse
);
  localparam int CODE_W    = 3;
  localparam int SYNC_STGS = 2;

  logic sync_lvl;
  logic smp_tick;

  pif_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_in),
    .q_out (sync_lvl)
  );

  pif_prescaler #(.CODE_W(CODE_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (psc_code),
    .full_in (base_full),
    .tick    (smp_tick)
  );

  pif_level_filter u_flt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (smp_tick),
    .smp   (sync_lvl),
    .three (three_smp),
    .lvl   (lvl_out),
    .rise  (rise_pulse),
    .fall  (fall_pulse)
  );

  // R10
  rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> (lvl_out && !$past(lvl_out)));
  // R10
  fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> (!lvl_out && $past(lvl_out)));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));
  // R3
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_out != $past(lvl_out)) |-> $past(smp_tick));
endmodule

// File: tb/tb_prescaled_input_filter.sv
`timescale 1ns/1ps
module tb_prescaled_input_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_in = 1'b0;
  logic [2:0] psc_code = 3'd0;
  logic       base_full = 1'b0;
  logic       three_smp = 1'b0;
  logic       lvl_out, rise_pulse, fall_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  bit seen_hi = 1'b0;
  int n_rise = 0;
  int n_fall = 0;

  always #2 clk = ~clk;

  prescaled_input_filter dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .psc_code(psc_code),
    .base_full(base_full), .three_smp(three_smp),
    .lvl_out(lvl_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  function automatic int exp_period(input logic [2:0] c, input logic f);
    int p;
    p = f ? 1 : 2;
    for (int i = 0; i < int'(c); i++) p = p * 2;
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: sliding history of samples, countdown to each tick.
  logic m_s1, m_s2, m_lvl, m_rise, m_fall;
  logic [2:0] m_hist;
  int m_left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
      m_hist = 3'b000; m_left = 2;
    end else begin
      bit agree;
      m_rise = 0; m_fall = 0;
      if (m_left == 1) begin
        m_hist = {m_hist[1:0], m_s2};
        if (three_smp) agree = (m_hist == 3'b111) || (m_hist == 3'b000);
        else           agree = (m_hist[1] == m_hist[0]);
        if (agree && (m_hist[0] != m_lvl)) begin
          m_lvl  = m_hist[0];
          m_rise = m_lvl;
          m_fall = !m_lvl;
        end
        m_left = exp_period(psc_code, base_full);
      end else begin
        m_left = m_left - 1;
      end
      m_s2 = m_s1;
      m_s1 = raw_in;
    end
  end

  always @(negedge clk) begin
    if (lvl_out) seen_hi = 1'b1;
    if (rise_pulse) n_rise++;
    if (fall_pulse) n_fall++;
    if (cmp_on && rst_n) begin
      chk(lvl_out == m_lvl, "R3 R4 R5 R6 R7 level vs model", lvl_out, m_lvl);
      chk(rise_pulse == m_rise && fall_pulse == m_fall, "R10 strobes vs model",
          {rise_pulse, fall_pulse}, {m_rise, m_fall});
    end
  end

  task automatic pulse_case(input logic [2:0] c, input logic f, input logic t,
                            input int w, input bit pass, input string tag);
    int per;
    @(negedge clk);
    psc_code = c; base_full = f; three_smp = t; raw_in = 0;
    repeat (1100) @(negedge clk);
    per = exp_period(c, f);
    repeat ($urandom % per) @(negedge clk);
    seen_hi = 0; n_rise = 0; n_fall = 0;
    raw_in = 1;
    repeat (w) @(negedge clk);
    raw_in = 0;
    repeat (4 * per + 10) @(negedge clk);
    chk(seen_hi == pass, tag, seen_hi, pass);
    if (pass) chk(n_rise == 1 && n_fall == 1, "R10 one rise and one fall", n_rise * 10 + n_fall, 11);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1
    chk(!lvl_out && !rise_pulse && !fall_pulse, "R1 during reset", {lvl_out, rise_pulse, fall_pulse}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk(!lvl_out && !rise_pulse && !fall_pulse, "R1 after reset", {lvl_out, rise_pulse, fall_pulse}, 0);

    // R2: period 1, two-sample, step timing
    psc_code = 3'd0; base_full = 1'b1; three_smp = 1'b0; raw_in = 0;
    repeat (20) @(negedge clk);
    raw_in = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lvl_out == 1'b0, "R2 not after third edge", lvl_out, 0);
    @(negedge clk);
    chk(lvl_out == 1'b1, "R2 after fourth edge", lvl_out, 1);
    raw_in = 0;
    repeat (10) @(negedge clk);

    // R7: toggling every cycle never passes
    seen_hi = 0;
    for (int k = 0; k < 30; k++) begin
      raw_in = ~raw_in;
      @(negedge clk);
    end
    raw_in = 0;
    repeat (10) @(negedge clk);
    chk(seen_hi == 0, "R7 toggling input rejected", seen_hi, 0);

    // R8 / R9 pulse width limits
    pulse_case(3'd0, 1'b0, 1'b0, 4, 1'b1, "R8 two-sample 4 clk passes");
    pulse_case(3'd0, 1'b0, 1'b0, 2, 1'b0, "R8 two-sample 2 clk rejected");
    pulse_case(3'd0, 1'b0, 1'b1, 6, 1'b1, "R8 three-sample 6 clk passes");
    pulse_case(3'd0, 1'b0, 1'b1, 4, 1'b0, "R8 three-sample 4 clk rejected");
    pulse_case(3'd7, 1'b0, 1'b0, 512, 1'b1, "R9 slowest 512 clk passes");
    pulse_case(3'd7, 1'b0, 1'b0, 256, 1'b0, "R9 slowest 256 clk rejected");
    pulse_case(3'd2, 1'b1, 1'b1, 12, 1'b1, "R6 period 4 three-sample 12 clk passes");
    pulse_case(3'd3, 1'b1, 1'b0, 8, 1'b0, "R5 period 8 two-sample 8 clk rejected");

    // Random phase: config changes at arbitrary times (R4) checked by the model
    for (int s = 0; s < 400; s++) begin
      if ($urandom % 4 == 0) begin
        psc_code  = 3'($urandom % 5);
        base_full = 1'($urandom % 2);
        three_smp = 1'($urandom % 2);
      end
      raw_in = 1'($urandom % 2);
      repeat (1 + ($urandom % (3 * exp_period(psc_code, base_full) + 2))) @(negedge clk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule